// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit turns one operand specifier into the value a datapath needs next: a memory address to fetch from or store to, or, for the modes that touch no memory, the operand itself. Each request carries an addressing-mode code, two register numbers (base and index), a constant field taken from the instruction, an element-size code and a flag saying whether the operand is a destination. The unit presents the two register numbers to an external register file and reads both contents back in the same cycle. The result is registered, so it appears one clock after the request.

Nine modes are supported: immediate, register, direct, register indirect, base plus index, base plus displacement, post-increment, pre-decrement and scaled index. The two stepping modes also raise a writeback request for the base register. Post-increment addresses memory at the old base and writes back the base plus the element size. Pre-decrement subtracts the element size first and uses the reduced value both as the address and as the writeback value. An immediate operand used as a destination, and any undefined mode code, are reported as illegal.

Top module: `eag_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, res_valid, res_mem, res_illegal and wb_valid are 0.
- R2: A request with req_valid=1 produces res_valid=1 exactly one clock later, and a cycle with req_valid=0 produces res_valid=0, res_mem=0 and wb_valid=0 one clock later.
- R3: Mode code 0 (immediate) as a source gives res_value = req_field and res_mem=0; as a destination (req_is_dst=1) it gives res_illegal=1, res_value=0, res_mem=0 and no writeback.
- R4: Mode code 1 (register) gives res_value = content of the base register and res_mem=0.
- R5: Mode code 2 (direct) gives res_value = req_field with res_mem=1.
- R6: Mode code 3 (register indirect) gives res_value = base register content with res_mem=1.
- R7: Mode code 4 (indexed) gives res_value = base + index register contents with res_mem=1; all address sums wrap modulo 2^AW.
- R8: Mode code 5 (displacement) gives res_value = req_field + base with res_mem=1.
- R9: Mode code 6 (post-increment) gives res_value = old base, res_mem=1, and a writeback of base + d.
- R10: Mode code 7 (pre-decrement) gives res_value = base - d, res_mem=1, and a writeback of the same value base - d.
- R11: Mode code 8 (scaled) gives res_value = req_field + base + index*d with res_mem=1.
- R12: The element size d is 2^req_size: size code 0,1,2,3 gives 1,2,4,8 bytes.
- R13: wb_valid is 1 only for modes 6 and 7, and then wb_reg equals the request's base register number.
- R14: Mode codes 9 to 15 give res_illegal=1, res_value=0, res_mem=0 and wb_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 4 | Addressing-mode code |
| req_is_dst | input | 1 | Operand is a destination |
| req_base | input | RW | Base register number |
| req_index | input | RW | Index register number |
| req_field | input | AW | Constant from the instruction |
| req_size | input | 2 | Element-size code |
| rf_base_idx | output | RW | Register file read address, base |
| rf_index_idx | output | RW | Register file read address, index |
| rf_base_data | input | AW | Base register content |
| rf_index_data | input | AW | Index register content |
| res_valid | output | 1 | Result present |
| res_value | output | AW | Effective address or operand value |
| res_mem | output | 1 | Result is a memory address |
| res_illegal | output | 1 | Request was illegal |
| wb_valid | output | 1 | Base register writeback request |
| wb_reg | output | RW | Register number to write back |
| wb_data | output | AW | Value to write back |

## Verification
The stepping modes are the one place where two outputs are produced in the same cycle: the memory address on res_value and the base update on wb_data, which coincide for pre-decrement and differ by d for post-increment. The bench provokes this with back-to-back post-increment and pre-decrement requests at every size code, including a pre-decrement from base 0 that must wrap, and the scoreboard judges the address, the writeback register and the writeback value of the same result cycle against one expected item. Undefined codes and an immediate destination are placed between them to show that neither raises a writeback.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [3:0] {
        AM_IMM    = 4'd0,
        AM_REG    = 4'd1,
        AM_DIR    = 4'd2,
        AM_RIND   = 4'd3,
        AM_IDX    = 4'd4,
        AM_DISP   = 4'd5,
        AM_AINC   = 4'd6,
        AM_ADEC   = 4'd7,
        AM_SCALED = 4'd8
    } am_e;

    // control word steering the shared adder and the writeback path
    typedef struct packed {
        logic legal;
        logic take_field;
        logic take_base;
        logic take_index;
        logic scale_index;
        logic sub_elem;
        logic touch_mem;
        logic upd_base;
        logic upd_down;
    } ctl_t;

    function automatic logic [3:0] elem_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/eag_mode_decode.sv
module eag_mode_decode
    import eag_pkg::*;
(
    input  logic [3:0] mode,
    input  logic       is_dst,
    output ctl_t       ctl
);
    always_comb begin
        ctl = '0;
        case (mode)
            AM_IMM: begin
                if (!is_dst) begin
                    ctl.legal      = 1'b1;
                    ctl.take_field = 1'b1;
                end
            end
            AM_REG: begin
                ctl.legal     = 1'b1;
                ctl.take_base = 1'b1;
            end
            AM_DIR: begin
                ctl.legal      = 1'b1;
                ctl.take_field = 1'b1;
                ctl.touch_mem  = 1'b1;
            end
            AM_RIND: begin
                ctl.legal     = 1'b1;
                ctl.take_base = 1'b1;
                ctl.touch_mem = 1'b1;
            end
            AM_IDX: begin
                ctl.legal      = 1'b1;
                ctl.take_base  = 1'b1;
                ctl.take_index = 1'b1;
                ctl.touch_mem  = 1'b1;
            end
            AM_DISP: begin
                ctl.legal      = 1'b1;
                ctl.take_field = 1'b1;
                ctl.take_base  = 1'b1;
                ctl.touch_mem  = 1'b1;
            end
            AM_AINC: begin
                ctl.legal     = 1'b1;
                ctl.take_base = 1'b1;
                ctl.touch_mem = 1'b1;
                ctl.upd_base  = 1'b1;
            end
            AM_ADEC: begin
                ctl.legal     = 1'b1;
                ctl.take_base = 1'b1;
                ctl.sub_elem  = 1'b1;
                ctl.touch_mem = 1'b1;
                ctl.upd_base  = 1'b1;
                ctl.upd_down  = 1'b1;
            end
            AM_SCALED: begin
                ctl.legal       = 1'b1;
                ctl.take_field  = 1'b1;
                ctl.take_base   = 1'b1;
                ctl.take_index  = 1'b1;
                ctl.scale_index = 1'b1;
                ctl.touch_mem   = 1'b1;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc
    import eag_pkg::*;
#(
    parameter int AW = 24
) (
    input  ctl_t          ctl,
    input  logic [AW-1:0] field,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] index,
    input  logic [1:0]    size,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] wb_sum
);
    logic [AW-1:0] elem;
    logic [AW-1:0] t_field;
    logic [AW-1:0] t_base;
    logic [AW-1:0] t_index;
    logic [AW-1:0] t_step;

    always_comb begin
        elem    = AW'(elem_bytes(size));
        t_field = ctl.take_field ? field : '0;
        t_base  = ctl.take_base  ? base  : '0;
        if (!ctl.take_index)
            t_index = '0;
        else if (ctl.scale_index)
            t_index = index << size;
        else
            t_index = index;
        t_step  = ctl.sub_elem ? (~elem + AW'(1)) : '0;
        addr    = t_field + t_base + t_index + t_step;
        wb_sum  = ctl.upd_down ? (base - elem) : (base + elem);
    end
endmodule

// File: rtl/eag_out_stage.sv
module eag_out_stage
    import eag_pkg::*;
#(
    parameter int AW = 24,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  ctl_t          ctl,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] wb_sum,
    input  logic [RW-1:0] base_idx,
    output logic          res_valid,
    output logic [AW-1:0] res_value,
    output logic          res_mem,
    output logic          res_illegal,
    output logic          wb_valid,
    output logic [RW-1:0] wb_reg,
    output logic [AW-1:0] wb_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_value   <= '0;
            res_mem     <= 1'b0;
            res_illegal <= 1'b0;
            wb_valid    <= 1'b0;
            wb_reg      <= '0;
            wb_data     <= '0;
        end else begin
            res_valid   <= in_valid;
            res_mem     <= in_valid & ctl.touch_mem;
            res_illegal <= in_valid & ~ctl.legal;
            wb_valid    <= in_valid & ctl.upd_base;
            if (in_valid) begin
                res_value <= addr;
                wb_reg    <= base_idx;
                wb_data   <= wb_sum;
            end
        end
    end
endmodule

// File: rtl/eag_unit.sv
module eag_unit
    import eag_pkg::*;
#(
    parameter int AW   = 24,
    parameter int NREG = 16,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [3:0]    req_mode,
    input  logic          req_is_dst,
    input  logic [RW-1:0] req_base,
    input  logic [RW-1:0] req_index,
    input  logic [AW-1:0] req_field,
    input  logic [1:0]    req_size,
    output logic [RW-1:0] rf_base_idx,
    output logic [RW-1:0] rf_index_idx,
    input  logic [AW-1:0] rf_base_data,
    input  logic [AW-1:0] rf_index_data,
    output logic          res_valid,
    output logic [AW-1:0] res_value,
    output logic          res_mem,
    output logic          res_illegal,
    output logic          wb_valid,
    output logic [RW-1:0] wb_reg,
    output logic [AW-1:0] wb_data
);
    ctl_t          ctl;
    logic [AW-1:0] addr;
    logic [AW-1:0] wb_sum;

    assign rf_base_idx  = req_base;
    assign rf_index_idx = req_index;

    eag_mode_decode u_dec (
        .mode   (req_mode),
        .is_dst (req_is_dst),
        .ctl    (ctl)
    );

    eag_addr_calc #(.AW(AW)) u_calc (
        .ctl    (ctl),
        .field  (req_field),
        .base   (rf_base_data),
        .index  (rf_index_data),
        .size   (req_size),
        .addr   (addr),
        .wb_sum (wb_sum)
    );

    eag_out_stage #(.AW(AW), .RW(RW)) u_out (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (req_valid),
        .ctl         (ctl),
        .addr        (addr),
        .wb_sum      (wb_sum),
        .base_idx    (req_base),
        .res_valid   (res_valid),
        .res_value   (res_value),
        .res_mem     (res_mem),
        .res_illegal (res_illegal),
        .wb_valid    (wb_valid),
        .wb_reg      (wb_reg),
        .wb_data     (wb_data)
    );
endmodule

// File: rtl/eag_unit_chk.sv
module eag_unit_chk
    import eag_pkg::*;
#(
    parameter int AW   = 24,
    parameter int NREG = 16,
    localparam int RW  = $clog2(NREG)
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [3:0]    req_mode,
    input logic          req_is_dst,
    input logic [RW-1:0] req_base,
    input logic [1:0]    req_size,
    input logic          res_valid,
    input logic [AW-1:0] res_value,
    input logic          res_mem,
    input logic          res_illegal,
    input logic          wb_valid,
    input logic [RW-1:0] wb_reg,
    input logic [AW-1:0] wb_data
);
    logic [1:0] size_q;
    always_ff @(posedge clk) begin
        if (rst) size_q <= '0;
        else     size_q <= req_size;
    end

    logic [AW-1:0] step_q;
    assign step_q = AW'(1) << size_q;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!res_valid && !wb_valid && !res_mem && !res_illegal));

    assert_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!res_valid && !res_mem && !wb_valid));

    assert_imm_dst_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == AM_IMM && req_is_dst) |=>
        (res_illegal && res_value == '0 && !res_mem && !wb_valid));

    assert_no_mem_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_mode == AM_IMM || req_mode == AM_REG)) |=> !res_mem);

    assert_post_inc_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == AM_AINC) |=>
        (wb_valid && wb_data == AW'(res_value + step_q)));

    assert_pre_dec_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == AM_ADEC) |=> (wb_valid && wb_data == res_value));

    assert_wb_reg_R13: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_mode == AM_AINC || req_mode == AM_ADEC)) |=>
        (wb_reg == $past(req_base)));

    assert_wb_only_step_R13: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (res_valid && res_mem && !res_illegal));

    assert_undef_code_R14: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode > 4'd8) |=> (res_illegal && !res_mem && !wb_valid));
endmodule

bind eag_unit eag_unit_chk #(.AW(AW), .NREG(NREG)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_mode    (req_mode),
    .req_is_dst  (req_is_dst),
    .req_base    (req_base),
    .req_size    (req_size),
    .res_valid   (res_valid),
    .res_value   (res_value),
    .res_mem     (res_mem),
    .res_illegal (res_illegal),
    .wb_valid    (wb_valid),
    .wb_reg      (wb_reg),
    .wb_data     (wb_data)
);

// File: tb/tb_eag_unit.sv
`timescale 1ns/1ps
module tb_eag_unit;
    localparam int AW = 24;
    localparam int NREG = 16;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [3:0]    req_mode = '0;
    logic          req_is_dst = 1'b0;
    logic [RW-1:0] req_base = '0;
    logic [RW-1:0] req_index = '0;
    logic [AW-1:0] req_field = '0;
    logic [1:0]    req_size = '0;
    logic [RW-1:0] rf_base_idx, rf_index_idx;
    logic [AW-1:0] rf_base_data, rf_index_data;
    logic          res_valid, res_mem, res_illegal, wb_valid;
    logic [AW-1:0] res_value, wb_data;
    logic [RW-1:0] wb_reg;

    logic [AW-1:0] rf [NREG];
    assign rf_base_data  = rf[rf_base_idx];
    assign rf_index_data = rf[rf_index_idx];

    always #10 clk = ~clk;

    eag_unit #(.AW(AW), .NREG(NREG)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .req_is_dst(req_is_dst), .req_base(req_base), .req_index(req_index),
        .req_field(req_field), .req_size(req_size),
        .rf_base_idx(rf_base_idx), .rf_index_idx(rf_index_idx),
        .rf_base_data(rf_base_data), .rf_index_data(rf_index_data),
        .res_valid(res_valid), .res_value(res_value), .res_mem(res_mem),
        .res_illegal(res_illegal), .wb_valid(wb_valid), .wb_reg(wb_reg),
        .wb_data(wb_data)
    );

    typedef struct {
        logic          v;
        logic [AW-1:0] value;
        logic          mem;
        logic          ill;
        logic          wbv;
        logic [RW-1:0] wbr;
        logic [AW-1:0] wbd;
        string         tag;
    } item_t;

    item_t q[$];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic item_t model(input logic v, input logic [3:0] m, input logic dst,
                                    input logic [RW-1:0] b, input logic [RW-1:0] i,
                                    input logic [AW-1:0] f, input logic [1:0] s);
        item_t it;
        logic [AW-1:0] d;
        d = AW'(1) << s;  // R12: size code n means 2^n bytes
        it.v = v; it.value = '0; it.mem = 0; it.ill = 0; it.wbv = 0; it.wbr = b; it.wbd = '0;
        it.tag = "R2";
        if (v) begin
            case (m)
                4'd0: if (dst) begin it.ill = 1; it.tag = "R3"; end
                      else begin it.value = f; it.tag = "R3"; end
                4'd1: begin it.value = rf[b]; it.tag = "R4"; end
                4'd2: begin it.value = f; it.mem = 1; it.tag = "R5"; end
                4'd3: begin it.value = rf[b]; it.mem = 1; it.tag = "R6"; end
                4'd4: begin it.value = rf[b] + rf[i]; it.mem = 1; it.tag = "R7"; end
                4'd5: begin it.value = f + rf[b]; it.mem = 1; it.tag = "R8"; end
                4'd6: begin it.value = rf[b]; it.mem = 1; it.wbv = 1;
                            it.wbd = rf[b] + d; it.tag = "R9"; end
                4'd7: begin it.value = rf[b] - d; it.mem = 1; it.wbv = 1;
                            it.wbd = rf[b] - d; it.tag = "R10"; end
                4'd8: begin it.value = f + rf[b] + (rf[i] << s); it.mem = 1; it.tag = "R11"; end
                default: begin it.ill = 1; it.tag = "R14"; end
            endcase
        end
        return it;
    endfunction

    task automatic drive(input logic v, input logic [3:0] m, input logic dst,
                         input logic [RW-1:0] b, input logic [RW-1:0] i,
                         input logic [AW-1:0] f, input logic [1:0] s);
        @(negedge clk);
        req_valid = v; req_mode = m; req_is_dst = dst; req_base = b;
        req_index = i; req_field = f; req_size = s;
        q.push_back(model(v, m, dst, b, i, f, s));
    endtask

    // monitor: one expected item per cycle after each driven request
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check({it.tag, " R2 valid"}, AW'(res_valid), AW'(it.v));
                check({it.tag, " R2 mem"}, AW'(res_mem), AW'(it.mem));
                check({it.tag, " R13 wb_valid"}, AW'(wb_valid), AW'(it.wbv));
                if (it.v) begin
                    check({it.tag, " value"}, res_value, it.value);
                    check({it.tag, " illegal"}, AW'(res_illegal), AW'(it.ill));
                end
                if (it.wbv) begin
                    check({it.tag, " R13 wb_reg"}, AW'(wb_reg), AW'(it.wbr));
                    check({it.tag, " wb_data"}, wb_data, it.wbd);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NREG; k++) rf[k] = AW'(32'h001000 + k * 32'h111);
        rf[0]  = 24'h000000;
        rf[3]  = 24'hFFFFF8;
        rf[5]  = 24'h000040;
        rf[9]  = 24'h000003;
        rf[12] = 24'h7FFFFF;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs clear under reset
        check("R1 res_valid", AW'(res_valid), '0);
        check("R1 wb_valid", AW'(wb_valid), '0);
        check("R1 res_mem", AW'(res_mem), '0);
        check("R1 res_illegal", AW'(res_illegal), '0);
        rst = 1'b0;

        drive(1, 4'd0, 0, 4'd1, 4'd2, 24'h00ABCD, 2'd0);  // R3 immediate source
        drive(1, 4'd0, 1, 4'd1, 4'd2, 24'h00ABCD, 2'd0);  // R3 immediate destination
        drive(1, 4'd1, 0, 4'd7, 4'd2, 24'h000000, 2'd0);  // R4
        drive(1, 4'd1, 1, 4'd12, 4'd2, 24'h123456, 2'd1); // R4 as destination
        drive(1, 4'd2, 0, 4'd7, 4'd2, 24'h345678, 2'd0);  // R5
        drive(0, 4'd2, 0, 4'd7, 4'd2, 24'h345678, 2'd0);  // R2 idle
        drive(1, 4'd3, 1, 4'd5, 4'd2, 24'h000000, 2'd2);  // R6
        drive(1, 4'd4, 0, 4'd5, 4'd9, 24'h000000, 2'd3);  // R7
        drive(1, 4'd4, 0, 4'd3, 4'd12, 24'h000000, 2'd0); // R7 wrap
        drive(1, 4'd5, 0, 4'd5, 4'd0, 24'h000100, 2'd0);  // R8
        drive(1, 4'd5, 0, 4'd3, 4'd0, 24'h000010, 2'd0);  // R8 wrap
        for (int s = 0; s < 4; s++) begin
            drive(1, 4'd6, 0, 4'd5, 4'd0, 24'h0, 2'(s)); // R9 each size, R12
            drive(1, 4'd7, 1, 4'd5, 4'd0, 24'h0, 2'(s)); // R10 each size, R12
            drive(1, 4'd8, 0, 4'd5, 4'd9, 24'h000200, 2'(s)); // R11 each scale
        end
        drive(1, 4'd7, 0, 4'd0, 4'd0, 24'h0, 2'd3);       // R10 wrap below zero
        drive(1, 4'd6, 0, 4'd3, 4'd0, 24'h0, 2'd3);       // R9 wrap above top
        drive(1, 4'd9, 0, 4'd5, 4'd9, 24'h000777, 2'd1);  // R14
        drive(1, 4'd6, 0, 4'd12, 4'd0, 24'h0, 2'd1);      // R9 after illegal
        drive(1, 4'd15, 1, 4'd5, 4'd9, 24'hFFFFFF, 2'd3); // R14
        drive(1, 4'd8, 1, 4'd3, 4'd12, 24'h000008, 2'd2); // R11 wrap
        drive(0, 4'd6, 0, 4'd5, 4'd0, 24'h0, 2'd0);       // R2 idle with stepping code
        drive(0, 4'd0, 0, 4'd0, 4'd0, 24'h0, 2'd0);
        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule